// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of a UART: it turns bytes into asynchronous frames on a transmit line and turns frames arriving on a receive line back into bytes. The frame layout (character length, optional parity and its sense, one or two stop bits) and the use of the clear-to-send input are chosen at run time by control inputs. Bit timing comes from an external oversampling tick: one bit lasts `OVS` ticks, 16 by default. The block does not divide the clock itself.

On the transmit side the engine pulls a byte from an external FIFO with a one-cycle pop strobe. It does this only when it is idle, enabled and allowed by flow control. A busy output covers the whole frame, so software can tell "FIFO empty" apart from "line quiet". On the receive side the engine synchronizes the line and finds the middle of the start bit, rejecting short glitches. It samples each later bit at its centre and pushes the finished byte with a one-cycle strobe. Parity and framing problems set flags that stay set until a clear input is held high. A break (a line held low) comes out as a zero byte with the framing flag set.

Each frame captures its layout when it starts, so a change to the control inputs takes effect at the next frame.

Top module: `uart_frame_engine`

## Requirements
- R1: `len_code` selects the character length as 8 minus the code (0 means 8 bits, 3 means 5 bits). Bits go out and come in least significant bit first, right after the start bit. A received byte has 0 in every bit above the character length.
- R2: When `par_en` is 1, one parity bit follows the data bits. With `par_odd`=1 the data bits plus the parity bit hold an odd number of ones; with `par_odd`=0 they hold an even number. A received parity bit that breaks this rule sets `err_parity`. When `par_en` is 0, no parity bit is sent or expected.
- R3: `stop_code`=1 gives two stop bits; any other code gives one. The receiver checks every configured stop bit, and a low sample in any of them sets `err_frame`.
- R4: With `two_wire`=0 a new character starts only while `cts` is 1. With `two_wire`=1 the value of `cts` has no effect.
- R5: `err_parity` and `err_frame` stay at 1 through any number of later error-free frames. They return to 0 only in the cycle after a cycle in which `clr_err` is 1, and a held clear keeps them at 0.
- R6: A line held low for longer than a whole frame yields exactly one pushed byte of value 0 with `err_frame` set. No further byte is produced until the line has gone high and then falls again.
- R7: `tx_busy` is 1 from the cycle after `txf_pop` until the end of the last stop bit, even when `txf_empty` is 1. While `tx_busy` is 0, `txd` is 1.
- R8: With `rx_en`=0 no byte is pushed, and the transmitter keeps working. With `tx_en`=0 no byte is popped.
- R9: A low pulse on `rxd` that has ended before the middle of the start bit produces no byte and no error flag.
- R10: `txf_pop` is a single-cycle strobe. In the cycle after it, `txd` is 0, which starts the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Oversampling tick, OVS per bit time |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| len_code | input | 2 | Character length code, length = 8 - code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_code | input | 2 | 1 = two stop bits, other codes = one |
| two_wire | input | 1 | 1 = ignore cts |
| cts | input | 1 | Clear to send, active high |
| clr_err | input | 1 | Level-held clear of both error flags |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Pop strobe to the transmit FIFO |
| txd | output | 1 | Serial transmit line |
| tx_busy | output | 1 | Frame in progress on txd |
| rxd | input | 1 | Serial receive line |
| rx_push | output | 1 | Push strobe to the receive FIFO |
| rx_data | output | 8 | Received byte, valid with rx_push |
| err_parity | output | 1 | Sticky parity-error flag |
| err_frame | output | 1 | Sticky framing-error flag |

## Verification
A frame on `txd` starts one cycle after the `txf_pop` strobe. The bench therefore takes the cycle in which it sees the pop as its time origin and samples each bit about half a bit time (OVS/2 ticks) into that bit, which leaves plenty of margin against tick phase. A received byte is pushed near the middle of the last stop bit, two synchronizer cycles plus one register after the line sample. The error flags follow the push by one more cycle. For these reasons the bench reads `rx_push`, `rx_data` and the flags only after the whole stimulus frame has been driven, on a falling clock edge. The no-effect cases (cts held off, receiver disabled, glitch) are checked by waiting a span longer than a frame and then confirming that the pop and push counts and the flags have not moved.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_PAR,
    FS_STOP
  } frame_st_t;

  // character length from the inverted 2-bit code
  function automatic logic [3:0] char_bits(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  // number of stop bits: code 1 gives two, all other codes give one
  function automatic logic [1:0] stop_bits(input logic [1:0] code);
    return (code == 2'd1) ? 2'd2 : 2'd1;
  endfunction

  // parity bit over the low nb bits; odd=1 makes the total count odd
  function automatic logic parity_bit(input logic [7:0] d, input logic [3:0] nb,
                                      input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nb)) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       cts_ok,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] nstop,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(OVS);

  frame_st_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]   idx_q, idx_d;
  logic [7:0]   sh_q, sh_d;
  logic [3:0]   nb_q, nb_d;
  logic         pe_q, pe_d;
  logic         pb_q, pb_d;
  logic [1:0]   ns_q, ns_d;
  logic         launch, bit_end;

  assign launch  = (st_q == FS_IDLE) && tx_en && !fifo_empty && cts_ok;
  assign bit_end = tick && (cnt_q == CW'(OVS - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    nb_d  = nb_q;
    pe_d  = pe_q;
    pb_d  = pb_q;
    ns_d  = ns_q;
    if (st_q != FS_IDLE && tick) cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    case (st_q)
      FS_IDLE: if (launch) begin
        st_d  = FS_START;
        cnt_d = '0;
        idx_d = '0;
        sh_d  = fifo_data;
        nb_d  = nbits;
        pe_d  = par_en;
        pb_d  = parity_bit(fifo_data, nbits, par_odd);
        ns_d  = nstop;
      end
      FS_START: if (bit_end) st_d = FS_DATA;
      FS_DATA: if (bit_end) begin
        sh_d = {1'b0, sh_q[7:1]};
        if (idx_q == nb_q - 4'd1) begin
          st_d  = pe_q ? FS_PAR : FS_STOP;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 4'd1;
        end
      end
      FS_PAR: if (bit_end) st_d = FS_STOP;
      FS_STOP: if (bit_end) begin
        if (idx_q == {2'b00, ns_q} - 4'd1) st_d = FS_IDLE;
        else idx_d = idx_q + 4'd1;
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      nb_q  <= 4'd8;
      pe_q  <= 1'b0;
      pb_q  <= 1'b0;
      ns_q  <= 2'd1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      nb_q  <= nb_d;
      pe_q  <= pe_d;
      pb_q  <= pb_d;
      ns_q  <= ns_d;
    end
  end

  always_comb begin
    case (st_q)
      FS_START: txd = 1'b0;
      FS_DATA:  txd = sh_q[0];
      FS_PAR:   txd = pb_q;
      default:  txd = 1'b1;
    endcase
  end

  assign fifo_pop = launch;
  assign busy     = (st_q != FS_IDLE);

endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_en,
  input  logic [3:0] nbits,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] nstop,
  input  logic       rxd,
  output logic       push,
  output logic [7:0] dout,
  output logic       perr,
  output logic       ferr
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  logic [2:0]    sync_q;
  logic          line, fall;
  frame_st_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic [3:0]    nb_q, nb_d;
  logic          pe_q, pe_d, po_q, po_d;
  logic [1:0]    ns_q, ns_d;
  logic          pacc_q, pacc_d, perr_q, perr_d, ferr_q, ferr_d;
  logic          push_q, push_d, pout_q, pout_d, fout_q, fout_d;
  logic [7:0]    dout_q, dout_d;
  logic          tick_mid, tick_end, fe_now;

  assign line     = sync_q[1];
  assign fall     = sync_q[2] && !sync_q[1];
  assign tick_mid = tick && (cnt_q == CW'(MID));
  assign tick_end = tick && (cnt_q == CW'(OVS - 1));
  assign fe_now   = ferr_q || !line;

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  idx_d = idx_q;  sh_d = sh_q;
    nb_d = nb_q;  pe_d = pe_q;    po_d = po_q;    ns_d = ns_q;
    pacc_d = pacc_q;  perr_d = perr_q;  ferr_d = ferr_q;
    push_d = 1'b0;  dout_d = dout_q;  pout_d = pout_q;  fout_d = fout_q;
    if (st_q != FS_IDLE && tick) cnt_d = tick_end ? '0 : cnt_q + 1'b1;
    if (!rx_en) begin
      st_d = FS_IDLE;
    end else begin
      case (st_q)
        FS_IDLE: if (fall) begin
          st_d = FS_START;  cnt_d = '0;  idx_d = '0;  sh_d = '0;
          pacc_d = 1'b0;  perr_d = 1'b0;  ferr_d = 1'b0;
          nb_d = nbits;  pe_d = par_en;  po_d = par_odd;  ns_d = nstop;
        end
        FS_START: if (tick_mid) begin
          st_d  = line ? FS_IDLE : FS_DATA;
          cnt_d = '0;
        end
        FS_DATA: if (tick_end) begin
          sh_d[idx_q[2:0]] = line;
          pacc_d = pacc_q ^ line;
          if (idx_q == nb_q - 4'd1) begin
            st_d  = pe_q ? FS_PAR : FS_STOP;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end
        FS_PAR: if (tick_end) begin
          perr_d = pacc_q ^ line ^ po_q;
          st_d   = FS_STOP;
        end
        FS_STOP: if (tick_end) begin
          if (idx_q == {2'b00, ns_q} - 4'd1) begin
            push_d = 1'b1;  dout_d = sh_q;  pout_d = perr_q;  fout_d = fe_now;
            st_d   = FS_IDLE;
          end else begin
            ferr_d = fe_now;
            idx_d  = idx_q + 4'd1;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 3'b111;
      st_q <= FS_IDLE;  cnt_q <= '0;  idx_q <= '0;  sh_q <= '0;
      nb_q <= 4'd8;  pe_q <= 1'b0;  po_q <= 1'b0;  ns_q <= 2'd1;
      pacc_q <= 1'b0;  perr_q <= 1'b0;  ferr_q <= 1'b0;
      push_q <= 1'b0;  dout_q <= '0;  pout_q <= 1'b0;  fout_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      st_q <= st_d;  cnt_q <= cnt_d;  idx_q <= idx_d;  sh_q <= sh_d;
      nb_q <= nb_d;  pe_q <= pe_d;  po_q <= po_d;  ns_q <= ns_d;
      pacc_q <= pacc_d;  perr_q <= perr_d;  ferr_q <= ferr_d;
      push_q <= push_d;  dout_q <= dout_d;  pout_q <= pout_d;  fout_q <= fout_d;
    end
  end

  assign push = push_q;
  assign dout = dout_q;
  assign perr = pout_q;
  assign ferr = fout_q;

endmodule

// File: rtl/uart_fe_err.sv
module uart_fe_err (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ev_valid,
  input  logic ev_perr,
  input  logic ev_ferr,
  output logic flag_perr,
  output logic flag_ferr
);
  logic pf_q, pf_d, ff_q, ff_d;

  always_comb begin
    if (clr) begin
      pf_d = 1'b0;
      ff_d = 1'b0;
    end else begin
      pf_d = pf_q || (ev_valid && ev_perr);
      ff_d = ff_q || (ev_valid && ev_ferr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      ff_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
      ff_q <= ff_d;
    end
  end

  assign flag_perr = pf_q;
  assign flag_ferr = ff_q;

endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] stop_code,
  input  logic       two_wire,
  input  logic       cts,
  input  logic       clr_err,
  input  logic       txf_empty,
  input  logic [7:0] txf_data,
  output logic       txf_pop,
  output logic       txd,
  output logic       tx_busy,
  input  logic       rxd,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       err_parity,
  output logic       err_frame
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic [3:0] nbits;
  logic [1:0] nstop;
  logic       rx_perr, rx_ferr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign nbits = char_bits(len_code);
  assign nstop = stop_bits(stop_code);

  uart_fe_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n_i), .tick(bit_tick), .tx_en(tx_en),
    .cts_ok(two_wire || cts), .nbits(nbits), .par_en(par_en),
    .par_odd(par_odd), .nstop(nstop), .fifo_empty(txf_empty),
    .fifo_data(txf_data), .fifo_pop(txf_pop), .txd(txd), .busy(tx_busy)
  );

  uart_fe_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n_i), .tick(bit_tick), .rx_en(rx_en),
    .nbits(nbits), .par_en(par_en), .par_odd(par_odd), .nstop(nstop),
    .rxd(rxd), .push(rx_push), .dout(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  uart_fe_err u_err (
    .clk(clk), .rst_n(rst_n_i), .clr(clr_err), .ev_valid(rx_push),
    .ev_perr(rx_perr), .ev_ferr(rx_ferr),
    .flag_perr(err_parity), .flag_ferr(err_frame)
  );

endmodule

// File: rtl/uart_fe_chk.sv
module uart_fe_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic two_wire,
  input logic cts,
  input logic clr_err,
  input logic txf_pop,
  input logic txd,
  input logic tx_busy,
  input logic rx_push,
  input logic err_parity,
  input logic err_frame
);

  a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> (two_wire || cts));

  a_r8_tx_off_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !txf_pop);

  a_r8_rx_off_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_push);

  a_r10_pop_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |=> (tx_busy && !txd && !txf_pop));

  a_r7_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r5_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (!err_parity && !err_frame));

  a_r5_sticky_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_err) |=> err_frame);

  a_r5_sticky_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !clr_err) |=> err_parity);

  a_r5_set_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_frame) || $rose(err_parity)) |-> $past(rx_push));

endmodule

bind uart_frame_engine uart_fe_chk u_chk (.*);

// File: tb/uart_frame_engine_test.sv
`timescale 1ns/1ps
module uart_frame_engine_test;
  localparam int BITCLK = 32;  // 16 ticks per bit, tick every 2 clocks

  logic clk, rst_n, bit_tick;
  logic tx_en, rx_en, par_en, par_odd, two_wire, cts, clr_err, txf_empty;
  logic [1:0] len_code, stop_code;
  logic [7:0] txf_data, rx_data;
  logic txf_pop, txd, tx_busy, rxd, rx_push, err_parity, err_frame;
  logic drv_rxd, loop_en;

  int total = 0, bad = 0, rx_cnt = 0, pop_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  assign rxd = loop_en ? txd : drv_rxd;

  uart_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .rx_en(rx_en),
    .len_code(len_code), .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code),
    .two_wire(two_wire), .cts(cts), .clr_err(clr_err), .txf_empty(txf_empty),
    .txf_data(txf_data), .txf_pop(txf_pop), .txd(txd), .tx_busy(tx_busy),
    .rxd(rxd), .rx_push(rx_push), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial bit_tick = 1'b0;
  always @(posedge clk) begin
    #1;
    bit_tick = rst_n ? ~bit_tick : 1'b0;
  end

  always @(negedge clk) begin
    if (rx_push) begin
      rx_cnt++;
      rx_last = rx_data;
    end
    if (txf_pop) pop_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] c);
    return 8 - int'(c);
  endfunction

  function automatic int sb_of(input logic [1:0] c);
    return (c == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  function automatic logic [7:0] mask_of(input logic [7:0] d, input int nb);
    return d & 8'((1 << nb) - 1);
  endfunction

  // expected line bits, start bit first
  task automatic build(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                       output logic [11:0] v, output int len);
    int nb = nb_of(len_code);
    int p = 0;
    v = '0;
    v[p] = 1'b0; p++;
    for (int i = 0; i < nb; i++) begin v[p] = d[i]; p++; end
    if (par_en) begin v[p] = par_of(d, nb, par_odd) ^ bad_par; p++; end
    for (int s = 0; s < sb_of(stop_code); s++) begin v[p] = 1'b1; p++; end
    if (bad_stop) v[p-1] = 1'b0;
    len = p;
  endtask

  // offer a byte, decode txd independently, check bits and busy window
  task automatic tx_frame(input logic [7:0] d, input string tag);
    logic [11:0] ev, cap;
    int len, w, el;
    bit busy_ok;
    build(d, 1'b0, 1'b0, ev, len);
    @(posedge clk); #1;
    txf_data = d; txf_empty = 1'b0;
    w = 0;
    do begin @(negedge clk); w++; end while (!txf_pop && w < 2000);
    chk(txf_pop, {tag, " R10 pop"}, txf_pop, 1);
    @(posedge clk); #1;
    txf_empty = 1'b1;
    @(negedge clk);
    cap = '0; el = 0; busy_ok = 1'b1;
    for (int k = 0; k < len; k++) begin
      repeat ((16 * k + 8) * 2 - el) @(negedge clk);
      el = (16 * k + 8) * 2;
      cap[k] = txd;
      busy_ok &= tx_busy;
    end
    chk(cap == ev, {tag, " R1 R2 R3 tx bits"}, cap, ev);
    chk(busy_ok, {tag, " R7 busy during frame"}, busy_ok, 1);
    repeat ((16 * len + 8) * 2 - el) @(negedge clk);
    chk(!tx_busy && txd, {tag, " R3 R7 frame ended"}, {tx_busy, txd}, 2'b01);
  endtask

  // drive a frame on rxd from the bench
  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    logic [11:0] v;
    int len;
    build(d, bad_par, bad_stop, v, len);
    @(posedge clk); #1;
    for (int k = 0; k < len; k++) begin
      drv_rxd = v[k];
      repeat (BITCLK) @(posedge clk);
      #1;
    end
    drv_rxd = 1'b1;
    repeat (20) @(negedge clk);
  endtask

  task automatic clear_errs();
    @(posedge clk); #1 clr_err = 1'b1;
    repeat (3) @(posedge clk);
    #1 clr_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] lc, input logic pe, input logic po,
                         input logic [1:0] sc);
    @(posedge clk); #1;
    len_code = lc; par_en = pe; par_odd = po; stop_code = sc;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int c0, p0;
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; tx_en = 1'b1; rx_en = 1'b1; par_en = 1'b0; par_odd = 1'b0;
    two_wire = 1'b1; cts = 1'b0; clr_err = 1'b0; txf_empty = 1'b1; txf_data = 8'h00;
    len_code = 2'd0; stop_code = 2'd0; drv_rxd = 1'b1; loop_en = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // reset state
    chk(txd && !tx_busy && !txf_pop && !rx_push && !err_parity && !err_frame,
        "R7 R10 reset state", {txd, tx_busy, rx_push, err_parity, err_frame}, 5'b10000);

    // directed TX: 8N1, 7 bits even parity 2 stop, 5 bits odd parity
    tx_frame(8'hA5, "8N1");
    set_cfg(2'd1, 1'b1, 1'b0, 2'd1);
    tx_frame(8'hD3, "7E2");
    set_cfg(2'd3, 1'b1, 1'b1, 2'd0);
    tx_frame(8'hF6, "5O1");

    // R4: cts gating, then two-wire ignoring cts
    set_cfg(2'd0, 1'b0, 1'b0, 2'd0);
    @(posedge clk); #1 two_wire = 1'b0; cts = 1'b0; txf_data = 8'h33; txf_empty = 1'b0;
    p0 = pop_cnt;
    repeat (400) @(negedge clk);
    chk(pop_cnt == p0 && !tx_busy && txd, "R4 cts low holds tx", pop_cnt - p0, 0);
    @(posedge clk); #1 cts = 1'b1;
    tx_frame(8'h33, "R4 cts high");
    @(posedge clk); #1 two_wire = 1'b1; cts = 1'b0;
    tx_frame(8'h44, "R4 two-wire");

    // R8: tx_en low blocks pop
    @(posedge clk); #1 tx_en = 1'b0; txf_empty = 1'b0;
    p0 = pop_cnt;
    repeat (100) @(negedge clk);
    chk(pop_cnt == p0 && !tx_busy, "R8 tx disabled no pop", pop_cnt - p0, 0);
    @(posedge clk); #1 tx_en = 1'b1; txf_empty = 1'b1;

    // directed RX
    c0 = rx_cnt;
    rx_frame(8'h3C, 1'b0, 1'b0);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h3C, "R1 rx 8N1", rx_last, 8'h3C);
    set_cfg(2'd3, 1'b0, 1'b0, 2'd0);
    c0 = rx_cnt;
    rx_frame(8'hFF, 1'b0, 1'b0);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h1F, "R1 rx 5 bits upper zero", rx_last, 8'h1F);
    chk(!err_parity && !err_frame, "R2 no error on good frame", {err_parity, err_frame}, 0);

    // R2 parity error, R5 sticky then level clear
    set_cfg(2'd0, 1'b1, 1'b0, 2'd0);
    c0 = rx_cnt;
    rx_frame(8'h5A, 1'b1, 1'b0);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h5A, "R2 data kept on parity error", rx_last, 8'h5A);
    chk(err_parity && !err_frame, "R2 parity flag", {err_parity, err_frame}, 2'b10);
    set_cfg(2'd0, 1'b1, 1'b1, 2'd0);
    rx_frame(8'h81, 1'b0, 1'b0);
    chk(err_parity && rx_last == 8'h81, "R5 parity flag sticky", err_parity, 1);
    clear_errs();
    chk(!err_parity && !err_frame, "R5 level clear", {err_parity, err_frame}, 0);

    // R3: second stop bit low is a framing error
    set_cfg(2'd0, 1'b0, 1'b0, 2'd1);
    rx_frame(8'h77, 1'b0, 1'b1);
    chk(err_frame && !err_parity, "R3 bad second stop", {err_parity, err_frame}, 2'b01);
    rx_frame(8'h11, 1'b0, 1'b0);
    chk(err_frame && rx_last == 8'h11, "R5 frame flag sticky", err_frame, 1);
    clear_errs();

    // R9 glitch rejection
    set_cfg(2'd0, 1'b0, 1'b0, 2'd0);
    c0 = rx_cnt;
    @(posedge clk); #1 drv_rxd = 1'b0;
    repeat (6) @(posedge clk);
    #1 drv_rxd = 1'b1;
    repeat (500) @(negedge clk);
    chk(rx_cnt == c0 && !err_frame && !err_parity, "R9 glitch ignored", rx_cnt - c0, 0);

    // R6 break
    c0 = rx_cnt;
    @(posedge clk); #1 drv_rxd = 1'b0;
    repeat (14 * BITCLK) @(posedge clk);
    #1 drv_rxd = 1'b1;
    repeat (50) @(negedge clk);
    chk(rx_cnt == c0 + 1, "R6 single break byte", rx_cnt - c0, 1);
    chk(rx_last == 8'h00 && err_frame, "R6 break data zero framing set",
        {rx_last, err_frame}, 9'h001);
    clear_errs();

    // R8: receiver off, transmitter still runs
    @(posedge clk); #1 rx_en = 1'b0;
    c0 = rx_cnt;
    rx_frame(8'h69, 1'b0, 1'b0);
    tx_frame(8'h96, "R8 tx while rx off");
    chk(rx_cnt == c0 && !err_frame, "R8 rx disabled no push", rx_cnt - c0, 0);
    @(posedge clk); #1 rx_en = 1'b1;

    // random loopback frames
    @(posedge clk); #1 loop_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      set_cfg(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 2));
      d = 8'($urandom);
      c0 = rx_cnt;
      tx_frame(d, "random");
      chk(rx_cnt == c0 + 1 && rx_last == mask_of(d, nb_of(len_code)),
          "R1 R2 R3 loopback data", rx_last, mask_of(d, nb_of(len_code)));
      chk(!err_parity && !err_frame, "R2 R3 loopback clean", {err_parity, err_frame}, 0);
    end
    @(posedge clk); #1 loop_en = 1'b0;

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule